// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of asynchronous external lines, one bit per line, with 23 lines by default. Each line is brought into the clock domain and compared with its value one cycle earlier. Software chooses per line whether a rising edge, a falling edge, both or neither counts as an event. A selected edge latches a pending flag for that line. The pending flags, gated by an interrupt enable mask, drive a level interrupt request. A second, independent enable mask turns selected edges into a one-cycle event pulse that can wake a sleeping consumer.

Software reaches the block through a plain register port: a byte address, a write strobe, write data, and combinational read data. Pending flags are cleared by writing ones to them. A software trigger register lets a driver raise any line's pending flag without an external edge. Register bits above the implemented line count cannot be written and always read as zero. A driver can therefore find the line count by writing all ones to the rising-edge select register and reading it back.

Top module: `xint_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x0000_0000, `irq_o` is low and `evt_o` is low.
- R2: Registers sit at these byte offsets: interrupt enable 0x00, event enable 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Bit i of each register belongs to line i. Bits at or above NUM_LINES ignore writes and read as zero, so writing 0xFFFF_FFFF to 0x08 reads back 0x007F_FFFF with the default 23 lines.
- R3: A line whose rising-select bit is set and whose falling-select bit is clear latches its pending bit on a 0-to-1 transition only.
- R4: A line whose falling-select bit is set and whose rising-select bit is clear latches its pending bit on a 1-to-0 transition only.
- R5: A line with both select bits set latches its pending bit on either transition.
- R6: A line with neither select bit set never latches a pending bit from its input.
- R7: Writing a 1 to a bit of the pending register (0x14) clears that bit. Writing a 0 leaves it unchanged.
- R8: If a selected edge and a clearing write reach the same line in the same clock cycle, the pending bit ends up set.
- R9: Pending bits latch whatever the interrupt enable mask holds. `irq_o` is high exactly when some pending bit has its interrupt enable bit set. It stays high until every enabled pending bit is cleared.
- R10: Every selected edge on a line whose event enable bit is set produces a one-cycle high pulse on `evt_o`, whatever the interrupt enable mask holds. Edges on lines without event enable produce no pulse.
- R11: Writing a 1 to bit i of the software trigger register (0x10) sets pending bit i and software trigger bit i. Software trigger bit i reads back 1 until pending bit i is cleared, and clears with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_i | input | NUM_LINES | Asynchronous external lines |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
The bench walks each line through all four edge-select settings. A design with the select bits swapped, or that flags the wrong direction, latches pending bits that should stay clear. It times a clearing write to land in the same cycle as a fresh edge. A design that gives the clear priority would lose that interrupt. It also clears one of two enabled pending lines and checks that the request stays high. A design that drops the request on any clear would leave the remaining line unserviced. Further checks cover write-zero to the pending register, unimplemented bits through all-ones writes, and the software trigger bit clearing together with its pending bit. They also count event pulses on lines that are masked for interrupts.

// File: rtl/xint_pkg.sv
// Shared definitions for the external interrupt controller.
// Assumes byte addresses of at most 8 bits reach the register decoder.
package xint_pkg;

    localparam int unsigned OFS_W = 8;

    // Register byte offsets; software depends on these positions.
    typedef enum logic [OFS_W-1:0] {
        REG_IEN  = 8'h00,
        REG_EEN  = 8'h04,
        REG_RSEL = 8'h08,
        REG_FSEL = 8'h0C,
        REG_SWT  = 8'h10,
        REG_PEND = 8'h14
    } xint_reg_e;

    // True when the byte address selects the given register.
    function automatic logic reg_match(input logic [OFS_W-1:0] a, input xint_reg_e r);
        return a == OFS_W'(r);
    endfunction

endpackage

// File: rtl/xint_sync_edge.sv
// Synchroniser and edge detector for a vector of asynchronous lines.
// Each line passes through SYNC_STAGES flops, then one more flop holds the
// previous synchronised value. rise_o/fall_o are one-cycle flags.
// Assumes SYNC_STAGES >= 2 and lines stay low (or stable) during reset.
module xint_sync_edge #(
    parameter int unsigned NUM_LINES   = 23,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    output logic [NUM_LINES-1:0] rise_o,
    output logic [NUM_LINES-1:0] fall_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][NUM_LINES-1:0] chain_q;
    logic [NUM_LINES-1:0]                  prev_q;

    // Shift the raw lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], line_i};
        end
    end

    // Hold the last synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= chain_q[LAST];
        end
    end

    // Compare current and previous value per line.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign rise_o[i] =  chain_q[LAST][i] & ~prev_q[i];
        assign fall_o[i] = ~chain_q[LAST][i] &  prev_q[i];
    end

endmodule

// File: rtl/xint_regs.sv
// Register file and address decoder for the external interrupt controller.
// Holds the interrupt enable, event enable and edge select registers.
// Turns writes to the pending and software trigger offsets into per-line
// clear and set strobes. Bits at or above NUM_LINES are dropped on write
// and read as zero. Assumes NUM_LINES <= DATA_W.
module xint_regs
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 23,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] swt_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [NUM_LINES-1:0] ien_o,
    output logic [NUM_LINES-1:0] een_o,
    output logic [NUM_LINES-1:0] rsel_o,
    output logic [NUM_LINES-1:0] fsel_o,
    output logic [NUM_LINES-1:0] clr_o,
    output logic [NUM_LINES-1:0] sw_set_o
);

    logic [OFS_W-1:0]     ofs;
    logic [NUM_LINES-1:0] wdat;
    logic [NUM_LINES-1:0] ien_q, een_q, rsel_q, fsel_q;
    logic [NUM_LINES-1:0] rd_sel;

    assign ofs  = OFS_W'(addr_i);
    assign wdat = wr_data_i[NUM_LINES-1:0];

    // Update the four plain control registers on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            een_q  <= '0;
            rsel_q <= '0;
            fsel_q <= '0;
        end else if (wr_en_i) begin
            if (reg_match(ofs, REG_IEN))  ien_q  <= wdat;
            if (reg_match(ofs, REG_EEN))  een_q  <= wdat;
            if (reg_match(ofs, REG_RSEL)) rsel_q <= wdat;
            if (reg_match(ofs, REG_FSEL)) fsel_q <= wdat;
        end
    end

    // Decode write-one strobes for the pending latch.
    always_comb begin
        clr_o    = '0;
        sw_set_o = '0;
        if (wr_en_i && reg_match(ofs, REG_PEND)) clr_o    = wdat;
        if (wr_en_i && reg_match(ofs, REG_SWT))  sw_set_o = wdat;
    end

    // Select the line vector addressed for reading.
    always_comb begin
        if      (reg_match(ofs, REG_IEN))  rd_sel = ien_q;
        else if (reg_match(ofs, REG_EEN))  rd_sel = een_q;
        else if (reg_match(ofs, REG_RSEL)) rd_sel = rsel_q;
        else if (reg_match(ofs, REG_FSEL)) rd_sel = fsel_q;
        else if (reg_match(ofs, REG_SWT))  rd_sel = swt_i;
        else if (reg_match(ofs, REG_PEND)) rd_sel = pend_i;
        else                               rd_sel = '0;
    end

    // Zero-extend so unimplemented bits read as zero.
    assign rd_data_o = DATA_W'(rd_sel);

    assign ien_o  = ien_q;
    assign een_o  = een_q;
    assign rsel_o = rsel_q;
    assign fsel_o = fsel_q;

endmodule

// File: rtl/xint_pend.sv
// Pending latch with write-one-to-clear and software trigger tracking.
// A set from an edge or a software trigger wins over a clear in the same
// cycle. A software trigger bit drops only when its pending bit is cleared.
module xint_pend #(
    parameter int unsigned NUM_LINES = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] hit_i,
    input  logic [NUM_LINES-1:0] sw_set_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] swt_o
);

    logic [NUM_LINES-1:0] pend_q, swt_q;
    logic [NUM_LINES-1:0] set_any, clr_eff;

    assign set_any = hit_i | sw_set_i;
    assign clr_eff = clr_i & ~set_any;

    // Latch pending flags; sets take priority over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_eff) | set_any;
        end
    end

    // Track software-raised lines until their pending flag is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swt_q <= '0;
        end else begin
            swt_q <= (swt_q & ~clr_eff) | sw_set_i;
        end
    end

    assign pend_o = pend_q;
    assign swt_o  = swt_q;

endmodule

// File: rtl/xint_ctrl.sv
// Top of the edge-triggered external interrupt controller.
// Lines are synchronised and edge-detected. Selected edges latch pending
// bits. The interrupt enable mask gates pending bits onto irq_o. The event
// enable mask gates fresh edges onto a registered one-cycle evt_o pulse.
// Assumes a single clock, synchronous active-low reset, NUM_LINES <= DATA_W.
module xint_ctrl #(
    parameter int unsigned NUM_LINES   = 23,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 irq_o,
    output logic                 evt_o
);

    logic [NUM_LINES-1:0] rise, fall, edge_hit;
    logic [NUM_LINES-1:0] ien, een, rsel, fsel;
    logic [NUM_LINES-1:0] clr, sw_set, pend, swt;
    logic                 evt_q;

    xint_sync_edge #(
        .NUM_LINES  (NUM_LINES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(ext_i),
        .rise_o(rise),
        .fall_o(fall)
    );

    xint_regs #(
        .NUM_LINES(NUM_LINES),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .pend_i   (pend),
        .swt_i    (swt),
        .rd_data_o(rd_data_o),
        .ien_o    (ien),
        .een_o    (een),
        .rsel_o   (rsel),
        .fsel_o   (fsel),
        .clr_o    (clr),
        .sw_set_o (sw_set)
    );

    // Qualify detected edges with the per-line polarity selects.
    assign edge_hit = (rise & rsel) | (fall & fsel);

    xint_pend #(
        .NUM_LINES(NUM_LINES)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (edge_hit),
        .sw_set_i(sw_set),
        .clr_i   (clr),
        .pend_o  (pend),
        .swt_o   (swt)
    );

    // Register the event pulse for any selected edge on an event-enabled line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= |(edge_hit & een);
        end
    end

    assign evt_o = evt_q;
    assign irq_o = |(pend & ien);

endmodule

// File: rtl/xint_ctrl_chk.sv
// Property checker for xint_ctrl, attached with the bind below.
// Observes ports plus the edge, event-enable and pending vectors.
module xint_ctrl_chk
    import xint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 23,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 wr_en_i,
    input logic [DATA_W-1:0]    wr_data_i,
    input logic [DATA_W-1:0]    rd_data_o,
    input logic                 irq_o,
    input logic                 evt_o,
    input logic [NUM_LINES-1:0] hit,
    input logic [NUM_LINES-1:0] een,
    input logic [NUM_LINES-1:0] pend
);

    logic [OFS_W-1:0] ofs;
    assign ofs = OFS_W'(addr_i);

    // First cycle out of reset shows no request and no pulse.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_o && !evt_o));

    // Unimplemented bits always read zero.
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o >> NUM_LINES) == '0);

    // A full clear with no concurrent set empties the cleared bits.
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && reg_match(ofs, REG_PEND) && hit == '0)
        |=> ((pend & $past(wr_data_i[NUM_LINES-1:0])) == '0));

    // Every selected edge leaves its pending bit set, even against a clear.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));

    // The request cannot drop without a register write.
    assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en_i) |=> irq_o);

    // A selected edge on an event-enabled line pulses evt_o next cycle.
    assert_evt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & een) != '0) |=> evt_o);

    // A software trigger write raises the pending bits it names.
    assert_sw_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && reg_match(ofs, REG_SWT))
        |=> ((pend & $past(wr_data_i[NUM_LINES-1:0])) == $past(wr_data_i[NUM_LINES-1:0])));

endmodule

bind xint_ctrl xint_ctrl_chk #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .irq_o    (irq_o),
    .evt_o    (evt_o),
    .hit      (edge_hit),
    .een      (een),
    .pend     (pend)
);

// File: tb/sim_xint_ctrl.sv
// Self-checking bench for xint_ctrl: vector table, then directed tests.
module sim_xint_ctrl;

    localparam int unsigned N      = 23;
    localparam int unsigned AW     = 8;
    localparam int unsigned DW     = 32;
    localparam time         PERIOD = 10ns;
    localparam int          NV     = 56;

    localparam int OP_WR = 0, OP_RD = 1, OP_PIN = 2, OP_IRQ = 3, OP_EVT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ext = '0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, evt;

    int n_chk = 0, n_bad = 0, evt_cnt = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    xint_ctrl #(.NUM_LINES(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_i(ext), .addr_i(addr),
        .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rdata),
        .irq_o(irq), .evt_o(evt)
    );

    // Count event pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && evt) evt_cnt++;

    function automatic logic [79:0] mk(input int op, input int req,
                                       input logic [7:0] a, input logic [31:0] d,
                                       input logic [31:0] e);
        return {3'(op), 5'(req), a, d, e};
    endfunction

    localparam logic [79:0] VEC [NV] = '{
        mk(OP_RD, 1, 8'h00, 0, 0),                 // R1
        mk(OP_RD, 1, 8'h04, 0, 0),                 // R1
        mk(OP_RD, 1, 8'h08, 0, 0),                 // R1
        mk(OP_RD, 1, 8'h0C, 0, 0),                 // R1
        mk(OP_RD, 1, 8'h10, 0, 0),                 // R1
        mk(OP_RD, 1, 8'h14, 0, 0),                 // R1
        mk(OP_IRQ, 1, 8'h00, 0, 0),                // R1
        mk(OP_EVT, 1, 8'h00, 0, 0),                // R1
        mk(OP_WR, 2, 8'h08, 32'hFFFF_FFFF, 0),
        mk(OP_RD, 2, 8'h08, 0, 32'h007F_FFFF),     // R2 line count discovery
        mk(OP_WR, 2, 8'h08, 32'h5, 0),
        mk(OP_WR, 2, 8'h0C, 32'h6, 0),
        mk(OP_RD, 2, 8'h0C, 0, 32'h6),             // R2
        mk(OP_WR, 10, 8'h04, 32'h4, 0),
        mk(OP_PIN, 3, 8'h00, 32'h1, 0),
        mk(OP_RD, 3, 8'h14, 0, 32'h1),             // R3 rising on line 0
        mk(OP_PIN, 4, 8'h00, 32'h3, 0),
        mk(OP_RD, 4, 8'h14, 0, 32'h1),             // R4 rising ignored on line 1
        mk(OP_PIN, 4, 8'h00, 32'h1, 0),
        mk(OP_RD, 4, 8'h14, 0, 32'h3),             // R4 falling on line 1
        mk(OP_PIN, 3, 8'h00, 32'h0, 0),
        mk(OP_RD, 3, 8'h14, 0, 32'h3),             // R3 falling ignored on line 0
        mk(OP_PIN, 5, 8'h00, 32'h4, 0),
        mk(OP_RD, 5, 8'h14, 0, 32'h7),             // R5 rising on line 2
        mk(OP_WR, 7, 8'h14, 32'h7, 0),
        mk(OP_RD, 7, 8'h14, 0, 32'h0),             // R7 clear by ones
        mk(OP_PIN, 5, 8'h00, 32'h0, 0),
        mk(OP_RD, 5, 8'h14, 0, 32'h4),             // R5 falling on line 2
        mk(OP_EVT, 10, 8'h00, 0, 32'd2),           // R10 two pulses, irq masked
        mk(OP_PIN, 6, 8'h00, 32'h8, 0),
        mk(OP_PIN, 6, 8'h00, 32'h0, 0),
        mk(OP_RD, 6, 8'h14, 0, 32'h4),             // R6 line 3 unselected
        mk(OP_WR, 7, 8'h14, 32'h0, 0),
        mk(OP_RD, 7, 8'h14, 0, 32'h4),             // R7 zero write keeps bit
        mk(OP_WR, 7, 8'h14, 32'h4, 0),
        mk(OP_RD, 7, 8'h14, 0, 32'h0),             // R7
        mk(OP_PIN, 9, 8'h00, 32'h1, 0),
        mk(OP_RD, 9, 8'h14, 0, 32'h1),             // R9 latches while masked
        mk(OP_IRQ, 9, 8'h00, 0, 0),                // R9 masked
        mk(OP_WR, 9, 8'h00, 32'h21, 0),
        mk(OP_IRQ, 9, 8'h00, 0, 1),                // R9 enabled
        mk(OP_WR, 11, 8'h10, 32'h20, 0),
        mk(OP_RD, 11, 8'h10, 0, 32'h20),           // R11 trigger bit reads back
        mk(OP_RD, 11, 8'h14, 0, 32'h21),           // R11 pending raised
        mk(OP_WR, 9, 8'h14, 32'h1, 0),
        mk(OP_IRQ, 9, 8'h00, 0, 1),                // R9 one enabled line remains
        mk(OP_RD, 11, 8'h10, 0, 32'h20),           // R11
        mk(OP_WR, 11, 8'h14, 32'h20, 0),
        mk(OP_IRQ, 9, 8'h00, 0, 0),                // R9 all cleared
        mk(OP_RD, 11, 8'h10, 0, 32'h0),            // R11 trigger bit follows clear
        mk(OP_RD, 11, 8'h14, 0, 32'h0),            // R11
        mk(OP_WR, 2, 8'h00, 32'hFFFF_FFFF, 0),
        mk(OP_RD, 2, 8'h00, 0, 32'h007F_FFFF),     // R2
        mk(OP_WR, 2, 8'h10, 32'hFF80_0000, 0),
        mk(OP_RD, 2, 8'h14, 0, 32'h0),             // R2 upper trigger bits dropped
        mk(OP_EVT, 10, 8'h00, 0, 32'd0)            // R10 no pulses off event lines
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input int req, input logic [7:0] a, input logic [31:0] exp);
        addr = AW'(a);
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        evt_cnt = 0;

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [4:0]  rq;
            logic [7:0]  a;
            logic [31:0] d, e;
            {op, rq, a, d, e} = VEC[i];
            case (int'(op))
                OP_WR:  bus_wr(a, d);
                OP_RD:  bus_rd(int'(rq), a, e);
                OP_PIN: begin
                    ext = d[N-1:0];
                    repeat (4) @(negedge clk);
                end
                OP_IRQ: check(int'(rq), {31'b0, irq}, e);
                default: begin
                    check(int'(rq), 32'(evt_cnt), e);
                    evt_cnt = 0;
                end
            endcase
        end

        // R8: clear write lands in the same cycle as a new edge on line 4.
        bus_wr(8'h08, 32'h10);
        bus_wr(8'h0C, 32'h10);
        ext[4] = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd(8, 8'h14, 32'h10);
        ext[4] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_wr(8'h14, 32'h10);
        bus_rd(8, 8'h14, 32'h10);          // R8 set beats clear
        bus_wr(8'h14, 32'h10);
        bus_rd(8, 8'h14, 32'h0);           // R8 plain clear afterwards

        // R1: reset in mid-run returns every register to zero.
        bus_wr(8'h10, 32'h3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_rd(1, 8'h00, 32'h0);
        bus_rd(1, 8'h08, 32'h0);
        bus_rd(1, 8'h0C, 32'h0);
        bus_rd(1, 8'h10, 32'h0);
        bus_rd(1, 8'h14, 32'h0);
        check(1, {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule